// File: doc/BRIEF.md
# Cascadable Serial Wiper Register Bank

This block is the digital control core of a six-channel, 64-step digital potentiometer. A host talks to it over a three-wire serial link made of an active-high select, a serial clock and a serial data line. These inputs are sampled by the block's own system clock. While select is high, each low-to-high transition of the serial clock shifts one data bit into a 48-bit shift register. That register holds one 8-bit field per channel.

The bit that leaves the far end of the register is always visible on a cascade output. Several banks can therefore be chained, each cascade output feeding the next bank's data input. When the last cascade output is fed back to the first data input, the host can read the settings back by clocking them around the ring. When select falls, each channel loads bits 5:0 of its field as its new wiper position. The exception is a field whose bits 7:6 are binary 11: that channel keeps its current position. Position 0 is the bottom tap and 63 the top tap.

Top module: `wiper_bank`

## Requirements
- R1: While reset is asserted, all six wiper positions are 0, the shift register is cleared and the cascade output is 0.
- R2: While select is low, serial clock and data activity is ignored: the cascade output does not change. A later transaction with no clock edges applies the same register contents as before.
- R3: While select is high, each low-to-high transition of the serial clock captures one data bit. Holding the clock high for several system cycles still captures only one bit. Bits enter LSB first, and channel 1's field is entered first, followed by channels 2 to 6. After 48 bits, channel n's field is bits 8n-1 to 8n-8 of the frame, counted from the first bit sent as bit 0.
- R4: On the falling edge of select, a channel whose field has bits 7:6 equal to 11 keeps its wiper position. A channel whose field has any other code in bits 7:6 (00, 01 or 10) takes bits 5:0 of its field as its new position.
- R5: Wiper positions change only on the falling edge of select. They stay stable during a transaction, including partway through a frame.
- R6: The cascade output always presents the bit at the output end of the shift register, whatever the state of select. While a new frame is shifted in, the cascade output sends the previous frame's bits in the order they were received.
- R7: Feeding the cascade output back to the data input for 48 clocks restores the register contents. The wiper positions are then unchanged after select falls.
- R8: If fewer than 48 clocks occur in a transaction, the fields are taken from whatever the partly shifted register holds when select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Serial port enable, active high |
| sclk | input | 1 | Serial clock; data is captured on its rising transition |
| sdin | input | 1 | Serial data input |
| cout | output | 1 | Cascade data output (bit at the register's output end) |
| wiper_pos | output | 36 | Six 6-bit wiper positions, channel 1 in bits 5:0 |

## Verification
Directed frames use known fields with each of the four codes in bits 7:6. They show whether the keep code is decoded on the correct bits and whether the fields line up with the right channels. Serial activity with select low, and transactions with no clock edges, show whether the idle state is really ignored. A feedback loop of 48 bits from the cascade output shows whether readback is lossless. Partial frames show whether the block commits a partly shifted register. Random frames of random length, some with the serial clock held high for several cycles, are compared bit by bit on the cascade output and field by field on the wipers against a bench model.

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int NCH = 6,
  parameter int FW  = 8,
  parameter int PW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk,
  input  logic              sdin,
  output logic              cout,
  output logic [NCH*PW-1:0] wiper_pos
);
  localparam int SRW = NCH * FW;

  logic [SRW-1:0] sr;
  logic           sclk_q;
  logic           sel_q;

  wire cap    = sel & sclk & ~sclk_q;
  wire commit = sel_q & ~sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      sel_q  <= sel;
      if (cap) sr <= {sdin, sr[SRW-1:1]};
    end
  end

  assign cout = sr[0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [FW-1:0] fld  = sr[c*FW +: FW];
    wire          keep = &fld[FW-1:FW-2];
    logic [PW-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pos <= '0;
      else if (commit && !keep) pos <= fld[PW-1:0];
    end

    assign wiper_pos[c*PW +: PW] = pos;
  end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int NCH = 6,
  parameter int FW  = 8,
  parameter int PW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              sclk,
  input logic              cout,
  input logic [NCH*PW-1:0] wiper_pos,
  input logic [NCH*FW-1:0] sr
);
  logic sel_d, sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d  <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sel_d  <= sel;
      sclk_d <= sclk;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (wiper_pos == '0 && !cout));

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(cout));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sclk && !sclk_d) |=> (cout == $past(sr[1])));

  assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_d && !sel) |=> $stable(wiper_pos));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d && !sel && sr[c*FW+FW-1 -: 2] == 2'b11)
      |=> $stable(wiper_pos[c*PW +: PW]));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d && !sel && sr[c*FW+FW-1 -: 2] != 2'b11)
      |=> (wiper_pos[c*PW +: PW] == $past(sr[c*FW +: PW])));
  end
endmodule

bind wiper_bank wiper_bank_chk #(.NCH(NCH), .FW(FW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .cout(cout),
  .wiper_pos(wiper_pos), .sr(sr)
);

// File: tb/wiper_bank_tb_top.sv
`timescale 1ns/1ps
module wiper_bank_tb_top;
  localparam int NCH = 6, FW = 8, PW = 6;
  localparam int SRW = NCH * FW;
  localparam int WW  = NCH * PW;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
  logic cout;
  logic [WW-1:0] wiper_pos;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [SRW-1:0] sr_m = '0;
  logic [WW-1:0]  w_m  = '0;

  always #10 clk = ~clk;

  wiper_bank #(.NCH(NCH), .FW(FW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
    .cout(cout), .wiper_pos(wiper_pos)
  );

  function automatic logic [WW-1:0] apply(input logic [SRW-1:0] s, input logic [WW-1:0] w);
    logic [WW-1:0] r = w;
    for (int c = 0; c < NCH; c++)
      if (s[c*FW+FW-1 -: 2] != 2'b11) r[c*PW +: PW] = s[c*FW +: PW];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [SRW-1:0] act, input logic [SRW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_w(input string req);
    check(wiper_pos == w_m, req, SRW'(wiper_pos), SRW'(w_m));
  endtask

  task automatic send_bit(input logic b, input int hold, input string req);
    @(negedge clk); sdin = b; sclk = 1'b1;
    if (sel) sr_m = {b, sr_m[SRW-1:1]};
    repeat (hold) @(negedge clk);
    @(negedge clk); sclk = 1'b0;
    check(cout == sr_m[0], req, SRW'(cout), SRW'(sr_m[0]));
  endtask

  task automatic start_txn();
    @(negedge clk); sel = 1'b1;
  endtask

  task automatic end_txn(input string req);
    @(negedge clk); sel = 1'b0;
    w_m = apply(sr_m, w_m);
    @(negedge clk); @(negedge clk);
    chk_w(req);
  endtask

  task automatic send_frame(input logic [SRW-1:0] d, input int n, input bit rnd_hold, input string req);
    start_txn();
    for (int i = 0; i < n; i++) send_bit(d[i], rnd_hold ? int'($urandom_range(0, 2)) : 0, req);
    end_txn(req);
  endtask

  function automatic logic [SRW-1:0] mk(input logic [7:0] f0, f1, f2, f3, f4, f5);
    return {f5, f4, f3, f2, f1, f0};
  endfunction

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [SRW-1:0] d;
    logic [WW-1:0] w_save;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(wiper_pos == '0, "R1 wipers in reset", SRW'(wiper_pos), '0);
    check(cout == 1'b0, "R1 cout in reset", SRW'(cout), '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_w("R1 after reset");

    d = mk(8'h05, 8'h3F, 8'h40 | 8'h11, 8'h80 | 8'h2A, 8'h00, 8'h01);
    send_frame(d, SRW, 0, "R3 R4 load codes 00 01 10");
    check(wiper_pos == {6'd1, 6'd0, 6'h2A, 6'h11, 6'h3F, 6'h05}, "R3 field order",
          SRW'(wiper_pos), SRW'({6'd1, 6'd0, 6'h2A, 6'h11, 6'h3F, 6'h05}));

    d = mk(8'hC7, 8'h12, 8'hFF, 8'h33, 8'hC0, 8'h3E);
    start_txn();
    for (int i = 0; i < SRW; i++) begin
      send_bit(d[i], 0, "R6 previous frame on cout");
      if (i == 20) chk_w("R5 stable mid frame");
    end
    end_txn("R4 keep code 11");

    for (int i = 0; i < 20; i++) begin
      @(negedge clk); sclk = ~sclk; sdin = $urandom_range(0, 1);
      check(cout == sr_m[0], "R2 idle cout", SRW'(cout), SRW'(sr_m[0]));
    end
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    chk_w("R2 idle no wiper change");
    start_txn();
    end_txn("R2 empty transaction");

    w_save = w_m;
    d = sr_m;
    start_txn();
    for (int i = 0; i < SRW; i++) send_bit(cout, 0, "R7 circular cout");
    check(sr_m == d, "R7 ring restored", sr_m, d);
    end_txn("R7 wipers after readback");
    check(wiper_pos == w_save, "R7 unchanged", SRW'(wiper_pos), SRW'(w_save));

    send_frame({$urandom, $urandom}, 10, 0, "R8 partial 10 bits");
    send_frame({$urandom, $urandom}, 47, 0, "R8 partial 47 bits");

    for (int k = 0; k < 40; k++) begin
      int n;
      n = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, SRW - 1)) : SRW;
      send_frame({$urandom, $urandom}, n, 1, n == SRW ? "R3 R4 random frame" : "R8 random partial");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule